// File: doc/BRIEF.md
# Round, Window and Clamp Output Stage

This block sits at the end of a filter datapath. It turns a 32-bit two's complement accumulator value into a 16-bit output word. The accumulator value carries 16 integer bits and 16 fractional bits. Each cycle a 4-bit index is captured together with the data. The index chooses one of sixteen programmable parameter sets. Each set holds a 32-bit rounding value, a 5-bit window position and a pair of signed 16-bit clamp bounds.

The stage works in a fixed order. First it adds the rounding value, and the sum saturates at the signed 32-bit extremes instead of wrapping. Next it cuts a 16-bit window out of the sum. Last, if the single global limit switch is on, it clamps the window between the bounds of the selected set. The result is registered. An active-low enable input controls whether the output is driven.

The parameter sets and the limit switch are written through a simple 16-bit register write port. Data presented on one rising edge appears on the output after the following rising edge.

Top module: `rsl_output_stage`

## Requirements
- R1: A synchronous active-low reset clears the output register, every parameter set (rounding 0, window position 0, both bounds 0) and the limit switch. With those cleared values, the output equals accumulator bits 15:0.
- R2: The accumulator value and the set index are captured on the same rising edge. Index value n uses set n. The result appears on `dout` after the next rising edge.
- R3: The rounding value is added to the accumulator as signed 32-bit numbers. A positive overflow gives 0x7FFFFFFF and a negative overflow gives 0x80000000. The sum never wraps.
- R4: A window position k in the range 0 to 16 outputs sum bits k+15 down to k. Positions 17 to 31 behave exactly like 16.
- R5: While the limit switch is off, the output equals the selected window unchanged, whatever the bounds are.
- R6: While the limit switch is on, the window is read as signed. A value below the lower bound outputs the lower bound. A value above the upper bound outputs the upper bound. Any other value passes unchanged.
- R7: When the limit switch is on and the upper bound is less than the lower bound, the upper bound wins, so every value outputs the upper bound.
- R8: `dout_drive` is 1 exactly while `out_en_n` is 0. The enable has no effect on the registered value on `dout`.
- R9: Write map, taken on a rising edge while `wr_en` is 1. For addresses with bit 7 = 0, bits 6:3 give the set and bits 2:0 give the field: 0 = rounding bits 15:0, 1 = rounding bits 31:16, 2 = window position (data bits 4:0), 3 = lower bound, 4 = upper bound. Address 0x80 sets the limit switch from data bit 0. Field codes 5 to 7 and the other addresses with bit 7 = 1 change nothing.
- R10: Rounding is applied before the window is cut. A carry out of the bits below the window therefore reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_in | input | 32 | Accumulator value, two's complement |
| set_sel | input | 4 | Parameter set index, captured with the data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | 16 | Registered result word |
| dout_drive | output | 1 | High while the output is driven |

## Verification
Saturation of the rounding sum and clamping by the limit bounds can act on the same word. A value saturated to an extreme can then be clamped again. To provoke this, the bench pairs accumulator values near the signed limits with large rounding values of the same sign. It uses a window position of 16 and tight or inverted bounds, and mixes such values into the random stream. A bench function judges each result: it saturates first, windows second and clamps last, so an error in the order of the steps shows up as a value mismatch.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
    parameter int ACC_W    = 32;
    parameter int OUT_W    = 16;
    parameter int NUM_SETS = 16;
    parameter int SEL_W    = 5;
    parameter int WDATA_W  = 16;
    parameter int FIELD_W  = 3;

    localparam int SET_W     = $clog2(NUM_SETS);
    localparam int ADDR_W    = FIELD_W + SET_W + 1;
    localparam int MAX_SHIFT = ACC_W - OUT_W;

    localparam logic [FIELD_W-1:0] FLD_RND_LO = 3'd0;
    localparam logic [FIELD_W-1:0] FLD_RND_HI = 3'd1;
    localparam logic [FIELD_W-1:0] FLD_SEL    = 3'd2;
    localparam logic [FIELD_W-1:0] FLD_LO     = 3'd3;
    localparam logic [FIELD_W-1:0] FLD_HI     = 3'd4;

    typedef struct packed {
        logic [ACC_W-1:0] rnd;
        logic [SEL_W-1:0] sel;
        logic [OUT_W-1:0] lo;
        logic [OUT_W-1:0] hi;
    } rsl_set_t;

    typedef struct packed {
        rsl_set_t [NUM_SETS-1:0] sets;
        logic                    lim_en;
    } rsl_bank_t;
endpackage

// File: rtl/rsl_param_bank.sv
module rsl_param_bank
    import rsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]   rd_idx,
    output rsl_set_t           rd_set,
    output logic               lim_en
);
    rsl_bank_t bank_d, bank_q;

    logic [SET_W-1:0]   w_idx;
    logic [FIELD_W-1:0] w_fld;

    always_comb begin
        bank_d = bank_q;
        w_idx  = wr_addr[FIELD_W +: SET_W];
        w_fld  = wr_addr[FIELD_W-1:0];
        if (wr_en) begin
            if (wr_addr[ADDR_W-1]) begin
                if (wr_addr[ADDR_W-2:0] == '0) begin
                    bank_d.lim_en = wr_data[0];
                end
            end else begin
                case (w_fld)
                    FLD_RND_LO: bank_d.sets[w_idx].rnd[WDATA_W-1:0]     = wr_data;
                    FLD_RND_HI: bank_d.sets[w_idx].rnd[ACC_W-1:WDATA_W] = wr_data;
                    FLD_SEL:    bank_d.sets[w_idx].sel = wr_data[SEL_W-1:0];
                    FLD_LO:     bank_d.sets[w_idx].lo  = wr_data[OUT_W-1:0];
                    FLD_HI:     bank_d.sets[w_idx].hi  = wr_data[OUT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_set = bank_q.sets[rd_idx];
    assign lim_en = bank_q.lim_en;
endmodule

// File: rtl/rsl_round_sat.sv
module rsl_round_sat
    import rsl_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] rnd,
    output logic [ACC_W-1:0] sum
);
    localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] ext;

    always_comb begin
        ext = {acc[ACC_W-1], acc} + {rnd[ACC_W-1], rnd};
        if (ext[ACC_W] != ext[ACC_W-1]) begin
            sum = ext[ACC_W] ? NEG_MIN : POS_MAX;
        end else begin
            sum = ext[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/rsl_window_clamp.sv
module rsl_window_clamp
    import rsl_pkg::*;
(
    input  logic [ACC_W-1:0] sum,
    input  logic [SEL_W-1:0] sel,
    input  logic             lim_en,
    input  logic [OUT_W-1:0] lo,
    input  logic [OUT_W-1:0] hi,
    output logic [OUT_W-1:0] res
);
    logic [SEL_W-1:0] shamt;
    logic [OUT_W-1:0] win;
    logic [OUT_W-1:0] low_cut;

    always_comb begin
        shamt = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
        win   = sum[shamt +: OUT_W];
        low_cut = ($signed(win) < $signed(lo)) ? lo : win;
        if (!lim_en) begin
            res = win;
        end else if ($signed(low_cut) > $signed(hi)) begin
            res = hi;
        end else begin
            res = low_cut;
        end
    end
endmodule

// File: rtl/rsl_output_stage.sv
module rsl_output_stage
    import rsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [SET_W-1:0]   set_sel,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               out_en_n,
    output logic [OUT_W-1:0]   dout,
    output logic               dout_drive
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [SET_W-1:0] idx;
        logic [OUT_W-1:0] word;
    } stage_t;

    stage_t st_d, st_q;

    rsl_set_t         cur_set;
    logic             lim_en;
    logic [ACC_W-1:0] cur_rnd;
    logic [SEL_W-1:0] cur_sel;
    logic [OUT_W-1:0] cur_lo;
    logic [OUT_W-1:0] cur_hi;
    logic [ACC_W-1:0] s1_acc;
    logic [ACC_W-1:0] rnd_sum;
    logic [OUT_W-1:0] res;

    rsl_param_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (st_q.idx),
        .rd_set  (cur_set),
        .lim_en  (lim_en)
    );

    assign cur_rnd = cur_set.rnd;
    assign cur_sel = cur_set.sel;
    assign cur_lo  = cur_set.lo;
    assign cur_hi  = cur_set.hi;
    assign s1_acc  = st_q.acc;

    rsl_round_sat u_round (
        .acc (s1_acc),
        .rnd (cur_rnd),
        .sum (rnd_sum)
    );

    rsl_window_clamp u_win (
        .sum    (rnd_sum),
        .sel    (cur_sel),
        .lim_en (lim_en),
        .lo     (cur_lo),
        .hi     (cur_hi),
        .res    (res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc  = acc_in;
        st_d.idx  = set_sel;
        st_d.word = res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.word;
    assign dout_drive = ~out_en_n;
endmodule

// File: rtl/rsl_output_stage_chk.sv
module rsl_output_stage_chk
    import rsl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] dout,
    input logic             lim_en,
    input logic [SEL_W-1:0] cur_sel,
    input logic [OUT_W-1:0] cur_lo,
    input logic [OUT_W-1:0] cur_hi,
    input logic [ACC_W-1:0] s1_acc,
    input logic [ACC_W-1:0] cur_rnd,
    input logic [ACC_W-1:0] rnd_sum
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> dout == '0);

    p_no_pos_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_acc[ACC_W-1] && !cur_rnd[ACC_W-1]) |-> !rnd_sum[ACC_W-1]);

    p_no_neg_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_acc[ACC_W-1] && cur_rnd[ACC_W-1]) |-> rnd_sum[ACC_W-1]);

    p_top_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !lim_en && cur_sel >= SEL_W'(MAX_SHIFT))
        |-> dout == $past(rnd_sum[ACC_W-1:MAX_SHIFT]));

    p_in_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lim_en && ($signed(cur_lo) <= $signed(cur_hi)))
        |-> ($signed(dout) >= $signed($past(cur_lo))) &&
            ($signed(dout) <= $signed($past(cur_hi))));

    p_inverted_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lim_en && ($signed(cur_hi) < $signed(cur_lo)))
        |-> dout == $past(cur_hi));
endmodule

bind rsl_output_stage rsl_output_stage_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dout    (dout),
    .lim_en  (lim_en),
    .cur_sel (cur_sel),
    .cur_lo  (cur_lo),
    .cur_hi  (cur_hi),
    .s1_acc  (s1_acc),
    .cur_rnd (cur_rnd),
    .rnd_sum (rnd_sum)
);

// File: tb/tb_rsl_output_stage.sv
module tb_rsl_output_stage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] acc_in = 0;
    logic [3:0]  set_sel = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        out_en_n = 0;
    logic [15:0] dout;
    logic        dout_drive;

    int checks = 0;
    int errors = 0;

    logic [31:0]        m_rnd [16];
    logic [4:0]         m_sel [16];
    logic signed [15:0] m_lo  [16];
    logic signed [15:0] m_hi  [16];
    logic               m_lim;

    logic [15:0] p1, p2;
    logic        v1 = 0, v2 = 0;
    string       t1, t2;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsl_output_stage dut (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .set_sel(set_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_en_n(out_en_n), .dout(dout), .dout_drive(dout_drive)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [31:0] a, input logic [3:0] s);
        longint t;
        logic [31:0] sum;
        int k;
        logic signed [15:0] w;
        t = longint'($signed(a)) + longint'($signed(m_rnd[s]));
        if (t > 64'sd2147483647) sum = 32'h7fff_ffff;
        else if (t < -64'sd2147483648) sum = 32'h8000_0000;
        else sum = t[31:0];
        k = (m_sel[s] > 5'd16) ? 16 : int'(m_sel[s]);
        w = 16'(sum >> k);
        if (m_lim) begin
            if (w < m_lo[s]) w = m_lo[s];
            if (w > m_hi[s]) w = m_hi[s];
        end
        return w;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 16; i++) begin
            m_rnd[i] = 0; m_sel[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
        end
        m_lim = 0;
    endtask

    // R9 address map: bit7=0 -> set in [6:3], field in [2:0]; 0x80 -> limit switch
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        if (a[7]) begin
            if (a[6:0] == 0) m_lim = d[0];
        end else begin
            case (a[2:0])
                3'd0: m_rnd[a[6:3]][15:0]  = d;
                3'd1: m_rnd[a[6:3]][31:16] = d;
                3'd2: m_sel[a[6:3]] = d[4:0];
                3'd3: m_lo[a[6:3]]  = d;
                3'd4: m_hi[a[6:3]]  = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_params(input logic [3:0] s, input logic [31:0] r, input logic [4:0] k,
                              input logic [15:0] lo, input logic [15:0] hi);
        wr({1'b0, s, 3'd0}, r[15:0]);
        wr({1'b0, s, 3'd1}, r[31:16]);
        wr({1'b0, s, 3'd2}, {11'd0, k});
        wr({1'b0, s, 3'd3}, lo);
        wr({1'b0, s, 3'd4}, hi);
    endtask

    task automatic step(input logic [31:0] a, input logic [3:0] s, input string tag);
        @(negedge clk);
        if (v2) chk(t2, {16'd0, dout}, {16'd0, p2});
        p2 = p1; v2 = v1; t2 = t1;
        acc_in = a; set_sel = s;
        p1 = model(a, s); v1 = 1; t1 = tag;
    endtask

    task automatic flush();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (v2) chk(t2, {16'd0, dout}, {16'd0, p2});
            p2 = p1; v2 = v1; t2 = t1; v1 = 0;
        end
        v2 = 0;
    endtask

    function automatic logic [31:0] rand_acc();
        case ($urandom_range(0, 3))
            0: return 32'h7fff_0000 | ($urandom & 32'hffff);
            1: return 32'h8000_0000 | ($urandom & 32'hffff);
            2: return $urandom & 32'h000f_ffff;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_model();
        repeat (3) @(negedge clk);
        chk("R1 dout in reset", {16'd0, dout}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 dout after reset", {16'd0, dout}, 0);

        // R1 cleared sets: output is low 16 bits
        step(32'h1234_5678, 4'd0, "R1 cleared map");
        step(32'hcafe_beef, 4'd9, "R1 cleared map set 9");
        flush();

        // R8 enable only affects drive flag
        out_en_n = 1;
        @(negedge clk);
        chk("R8 drive off", {31'd0, dout_drive}, 0);
        chk("R8 value kept", {16'd0, dout}, 32'h0000_beef);
        out_en_n = 0;
        @(negedge clk);
        chk("R8 drive on", {31'd0, dout_drive}, 1);

        // R9 unused field codes and addresses ignored
        wr({1'b0, 4'd0, 3'd5}, 16'h0003);
        wr({1'b0, 4'd0, 3'd7}, 16'hffff);
        wr(8'h81, 16'h0001);
        step(32'h0001_2345, 4'd0, "R9 ignored writes");
        flush();

        // R3 saturation both signs, window 16
        set_params(4'd1, 32'h7fff_ffff, 5'd16, 16'h0000, 16'h0000);
        set_params(4'd2, 32'h8000_0000, 5'd16, 16'h0000, 16'h0000);
        step(32'h7fff_ffff, 4'd1, "R3 positive saturation");
        step(32'h8000_0000, 4'd2, "R3 negative saturation");
        step(32'h0000_0001, 4'd1, "R3 no overflow");
        flush();

        // R10 rounding carry reaches window; R4 positions 20 and 31 act as 16
        set_params(4'd3, 32'h0000_8000, 5'd16, 16'h0000, 16'h0000);
        set_params(4'd4, 32'h0000_0000, 5'd20, 16'h0000, 16'h0000);
        set_params(4'd5, 32'h0000_0000, 5'd31, 16'h0000, 16'h0000);
        set_params(4'd6, 32'h0000_0000, 5'd4, 16'h0000, 16'h0000);
        step(32'h0001_8000, 4'd3, "R10 round before window");
        step(32'habcd_1234, 4'd4, "R4 position 20 as 16");
        step(32'h1357_9bdf, 4'd5, "R4 position 31 as 16");
        step(32'h0012_3456, 4'd6, "R4 position 4");
        // R2 set n selects set n, back to back
        step(32'h0001_8000, 4'd6, "R2 index switch");
        step(32'h0001_8000, 4'd3, "R2 index switch back");
        flush();

        // R5 limit off with tight bounds
        set_params(4'd7, 32'h0, 5'd0, 16'd10, 16'd20);
        set_params(4'd8, 32'h0, 5'd0, 16'd50, 16'hffce);
        step(32'h0000_01f4, 4'd7, "R5 limit off passes");
        flush();
        wr(8'h80, 16'h0001);
        step(32'h0000_01f4, 4'd7, "R6 clamp high");
        step(32'hffff_fe0c, 4'd7, "R6 clamp low");
        step(32'h0000_000f, 4'd7, "R6 inside passes");
        step(32'h0000_0000, 4'd8, "R7 inverted low value");
        step(32'h0000_0064, 4'd8, "R7 inverted high value");
        // saturation and clamp together
        set_params(4'd9, 32'h7fff_ffff, 5'd16, 16'hff00, 16'h0100);
        step(32'h7fff_0000, 4'd9, "R3 R6 saturate then clamp");
        flush();

        // random blocks, R2 R3 R4 R5 R6 R7
        for (int blk = 0; blk < 8; blk++) begin
            for (int s = 0; s < 16; s++) begin
                logic [31:0] r;
                r = ($urandom_range(0, 1) == 0) ? ($urandom & 32'h0000_ffff) : $urandom;
                set_params(4'(s), r, 5'($urandom), 16'($urandom), 16'($urandom));
            end
            wr(8'h80, 16'($urandom_range(0, 1)));
            for (int n = 0; n < 400; n++) begin
                step(rand_acc(), 4'($urandom), "R2 random stream");
            end
            flush();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule